// File: doc/BRIEF.md
# Two-Way Tag Directory with Hit Detection

This block holds the tag directory of a 2 KB, two-way set-associative cache with 64-byte lines and 16-bit byte addresses. A lookup request splits its address into a byte offset, a set number and a tag. Both stored tags of the chosen set are compared with the request tag at the same time. One clock later the block reports whether the lookup hit, which way hit, and which way should be replaced if the line has to be brought in. A fill request names a set, a way and a tag, and writes that tag in one cycle. The data array, the bus side, dirty-line write-back and coherence are handled by other logic.

No valid bits are kept. The all-ones tag value marks an empty way and never matches. An address whose tag field is all ones is treated as non-cacheable. After reset, a sweep of sixteen cycles empties every way. Each set has one least-recently-used bit that chooses the victim.

Top module: `tag_dir2w`

## Requirements
- R1: Address bits [5:0] are the byte offset and do not affect the result. Bits [9:6] select one of 16 sets. Bits [15:10] form the 6-bit tag that is compared.
- R2: After reset is released, `busy` stays high for exactly 16 rising edges and then stays low. At the end of the sweep, every way of every set is empty. While `busy` is high, lookups produce no result (`res_valid` stays 0) and fills are dropped.
- R3: A lookup accepted on one clock edge sets `res_valid` to 1 after that edge, and `res_valid` is 0 after any edge with no accepted lookup. `res_hit`, `res_way` and `res_victim` belong to the same edge.
- R4: A lookup hits when one way of its set holds its tag. `res_way` gives that way: 0 for the first way, 1 for the second. On a miss, `res_way` is 0.
- R5: The tag value 6'b111111 marks an empty way and never produces a hit. A lookup whose tag is 6'b111111 always misses. A fill whose tag is 6'b111111 has no effect on the stored tags or on the replacement bit.
- R6: `res_victim` is way 0 if way 0 of the set is empty. Otherwise it is way 1 if way 1 is empty. Otherwise it is the way that the set's replacement bit points to.
- R7: A hit on way w, or a fill into way w, sets the set's replacement bit to point at the other way. A miss leaves the bit unchanged. After reset, the bit points at way 0.
- R8: A fill writes its tag in a single cycle, so a lookup on the next cycle already sees it. When a fill and a lookup address the same set in the same cycle, the lookup sees the filled contents, and the replacement bit takes the fill's update.
- R9: The two ways of a set never match the same lookup. A fill whose tag equals the tag held in the other way of that set empties the other way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 16 | Byte address to look up |
| fill_en | input | 1 | Fill request |
| fill_set | input | 4 | Set written by the fill |
| fill_way | input | 1 | Way written by the fill |
| fill_tag | input | 6 | Tag written by the fill |
| busy | output | 1 | High while the post-reset sweep runs |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | The lookup hit |
| res_way | output | 1 | Way that hit (0 on a miss) |
| res_victim | output | 1 | Way to replace for this lookup |

## Verification
A corrupted stored tag shows at the ports only when its set is next looked up. It appears as a wrong `res_hit` or `res_way` one cycle after that lookup. A wrong replacement bit does not change any hit result. It shows only in `res_victim`, and only once both ways of the set are full. The stimulus therefore fills sets completely, hits and misses them in chosen orders, and reads the victim after each step. Random traffic uses a small pool of tags, so most sets are revisited often and a stale entry is caught within a few lookups.

// File: rtl/tag_dir2w.sv
module tag_dir2w #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 6,
  parameter int SET_W  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           lk_valid,
  input  logic [ADDR_W-1:0]              lk_addr,
  input  logic                           fill_en,
  input  logic [SET_W-1:0]               fill_set,
  input  logic                           fill_way,
  input  logic [ADDR_W-OFF_W-SET_W-1:0]  fill_tag,
  output logic                           busy,
  output logic                           res_valid,
  output logic                           res_hit,
  output logic                           res_way,
  output logic                           res_victim
);
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;
  localparam int SETS  = 1 << SET_W;
  localparam logic [TAG_W-1:0] EMPTY = '1;

  logic [TAG_W-1:0] way0_q [SETS];
  logic [TAG_W-1:0] way1_q [SETS];
  logic [SETS-1:0]  lru_q;
  logic [SET_W-1:0] clr_q;
  logic             busy_q;

  wire [TAG_W-1:0] lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
  wire [SET_W-1:0] lk_set = lk_addr[OFF_W +: SET_W];
  wire lk_go   = lk_valid & ~busy_q;
  wire fill_go = fill_en & ~busy_q & (fill_tag != EMPTY);

  wire [TAG_W-1:0] f_old0 = way0_q[fill_set];
  wire [TAG_W-1:0] f_old1 = way1_q[fill_set];
  wire [TAG_W-1:0] f_new0 = fill_way ? ((f_old0 == fill_tag) ? EMPTY : f_old0) : fill_tag;
  wire [TAG_W-1:0] f_new1 = fill_way ? fill_tag : ((f_old1 == fill_tag) ? EMPTY : f_old1);

  wire same_set = fill_go & (fill_set == lk_set);
  wire [TAG_W-1:0] e0 = same_set ? f_new0 : way0_q[lk_set];
  wire [TAG_W-1:0] e1 = same_set ? f_new1 : way1_q[lk_set];
  wire e_lru = same_set ? ~fill_way : lru_q[lk_set];

  wire m0 = (e0 == lk_tag) & (lk_tag != EMPTY);
  wire m1 = (e1 == lk_tag) & (lk_tag != EMPTY);
  wire victim = (e0 == EMPTY) ? 1'b0 : (e1 == EMPTY) ? 1'b1 : e_lru;

  assign busy = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b1;
      clr_q      <= '0;
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_way    <= 1'b0;
      res_victim <= 1'b0;
    end else begin
      if (busy_q) begin
        clr_q <= clr_q + 1'b1;
        if (clr_q == '1) busy_q <= 1'b0;
      end
      res_valid <= lk_go;
      if (lk_go) begin
        res_hit    <= m0 | m1;
        res_way    <= m1;
        res_victim <= victim;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy_q) begin
      way0_q[clr_q] <= EMPTY;
      way1_q[clr_q] <= EMPTY;
      lru_q[clr_q]  <= 1'b0;
    end else begin
      if (fill_go) begin
        way0_q[fill_set] <= f_new0;
        way1_q[fill_set] <= f_new1;
        lru_q[fill_set]  <= ~fill_way;
      end
      if (lk_go && (m0 || m1) && !same_set)
        lru_q[lk_set] <= m0;
    end
  end
endmodule

// File: rtl/tag_dir2w_chk.sv
module tag_dir2w_chk #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 6,
  parameter int SET_W  = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          lk_valid,
  input logic [ADDR_W-1:0]             lk_addr,
  input logic                          fill_en,
  input logic [SET_W-1:0]              fill_set,
  input logic                          fill_way,
  input logic [ADDR_W-OFF_W-SET_W-1:0] fill_tag,
  input logic                          busy,
  input logic                          res_valid,
  input logic                          res_hit,
  input logic                          res_way,
  input logic                          match0,
  input logic                          match1
);
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;

  // R9
  dual_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({match0, match1}));

  // R2
  busy_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);

  // R3
  res_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !busy |=> res_valid);

  // R5
  reserved_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !busy && (lk_addr[ADDR_W-1 -: TAG_W] == '1) |=> !res_hit);

  // R8
  fill_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && !busy && (fill_tag != '1) && lk_valid &&
    (lk_addr[OFF_W +: SET_W] == fill_set) && (lk_addr[ADDR_W-1 -: TAG_W] == fill_tag)
    |=> res_hit && (res_way == $past(fill_way)));
endmodule

bind tag_dir2w tag_dir2w_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag),
  .busy(busy), .res_valid(res_valid), .res_hit(res_hit), .res_way(res_way),
  .match0(m0), .match1(m1));

// File: tb/tag_dir2w_tb.sv
`timescale 1ns/1ps
module tag_dir2w_tb;
  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, fill_en = 0, fill_way = 0;
  logic [15:0] lk_addr = '0;
  logic [3:0] fill_set = '0;
  logic [5:0] fill_tag = '0;
  logic busy, res_valid, res_hit, res_way, res_victim;
  int checks = 0, errors = 0;
  int mt0 [16];
  int mt1 [16];
  int ml [16];

  always #2.5 clk = ~clk;

  tag_dir2w u_dut (.clk, .rst_n, .lk_valid, .lk_addr, .fill_en, .fill_set, .fill_way,
    .fill_tag, .busy, .res_valid, .res_hit, .res_way, .res_victim);

  function automatic logic [15:0] mk(input int tag, input int set, input int off);
    return {tag[5:0], set[3:0], off[5:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit lv, input logic [15:0] la, input bit fe, input int fs,
                      input bit fw, input int ft, input string req);
    int t, s, h0, h1, vic;
    bit fgo;
    logic [3:0] ex;
    @(negedge clk);
    lk_valid = lv; lk_addr = la; fill_en = fe; fill_set = fs[3:0]; fill_way = fw; fill_tag = ft[5:0];
    fgo = fe && ft != 63;
    if (fgo) begin
      if (!fw) begin mt0[fs] = ft; if (mt1[fs] == ft) mt1[fs] = 63; end
      else begin mt1[fs] = ft; if (mt0[fs] == ft) mt0[fs] = 63; end
      ml[fs] = fw ? 0 : 1;
    end
    t = la[15:10]; s = la[9:6];
    h0 = (mt0[s] == t && t != 63); h1 = (mt1[s] == t && t != 63);
    vic = (mt0[s] == 63) ? 0 : (mt1[s] == 63) ? 1 : ml[s];
    if (lv && (h0 || h1) && !(fgo && fs == s)) ml[s] = h0 ? 1 : 0;
    ex = lv ? {1'b1, 1'(h0 || h1), 1'(h1), 1'(vic)} : 4'b0;
    @(posedge clk); #1;
    if (lv) chk({res_valid, res_hit, res_way, res_victim} == ex, req,
                {res_valid, res_hit, res_way, res_victim}, ex);
    else chk(res_valid == 1'b0, req, res_valid, 0);
    lk_valid = 0; fill_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 16; i++) begin mt0[i] = 63; mt1[i] = 63; ml[i] = 0; end
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk(busy == 1'b1 && res_valid == 1'b0, "R2 reset state", {busy, res_valid}, 2'b10);
    @(negedge clk); rst_n = 1;
    lk_valid = 1; lk_addr = mk(1, 1, 0); fill_en = 1; fill_set = 1; fill_tag = 1;
    n = 0;
    while (busy && n < 40) begin @(posedge clk); #1; n++;
      chk(res_valid == 1'b0, "R2 lookup during busy", res_valid, 0); end
    lk_valid = 0; fill_en = 0;
    chk(n == 16, "R2 busy length", n, 16);
    repeat (3) @(posedge clk); #1;
    chk(busy == 1'b0, "R2 busy stays low", busy, 0);

    step(1, mk(1, 1, 0), 0, 0, 0, 0, "R2 fill during busy dropped");
    step(0, 0, 0, 0, 0, 0, "R3 no lookup no result");
    step(1, mk(5, 3, 0), 0, 0, 0, 0, "R6 empty set victim way0");
    step(0, 0, 1, 3, 0, 5, "R8 fill");
    step(1, mk(5, 3, 17), 0, 0, 0, 0, "R4 hit way0 next cycle");
    step(1, mk(5, 3, 63), 0, 0, 0, 0, "R1 offset ignored");
    step(1, mk(5, 4, 17), 0, 0, 0, 0, "R1 other set misses");
    step(1, mk(7, 3, 0), 0, 0, 0, 0, "R6 way1 empty victim");
    step(0, 0, 1, 3, 1, 9, "R8 fill way1");
    step(1, mk(9, 3, 2), 0, 0, 0, 0, "R4 hit way1");
    step(1, mk(7, 3, 0), 0, 0, 0, 0, "R7 lru after hit way1");
    step(1, mk(5, 3, 0), 0, 0, 0, 0, "R7 hit way0");
    step(1, mk(7, 3, 0), 0, 0, 0, 0, "R7 lru points way1");
    step(1, mk(7, 3, 0), 0, 0, 0, 0, "R7 miss leaves lru");
    step(1, mk(63, 3, 0), 0, 0, 0, 0, "R5 reserved tag misses");
    step(0, 0, 1, 3, 0, 63, "R5 reserved fill");
    step(1, mk(5, 3, 0), 0, 0, 0, 0, "R5 reserved fill ignored");
    step(1, mk(12, 6, 0), 1, 6, 1, 12, "R8 same-cycle fill forwards");
    step(1, mk(12, 6, 0), 1, 6, 0, 12, "R9 duplicate fill empties other way");
    step(1, mk(3, 6, 0), 0, 0, 0, 0, "R9 other way now empty");

    for (int k = 0; k < 4000; k++) begin
      int t, ft;
      t  = ($urandom % 10 == 0) ? 63 : $urandom % 6;
      ft = ($urandom % 12 == 0) ? 63 : $urandom % 6;
      step($urandom % 4 != 0, mk(t, $urandom % 4, $urandom % 64),
           $urandom % 3 == 0, $urandom % 4, $urandom % 2, ft, "R4 R6 R7 R8 R9 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule